// File: doc/BRIEF.md
# Staged Self-Check Bring-Up Sequencer

This controller brings a system up through an ordered ladder of eleven health-check stages, numbered 0 to 10, where stage 10 gates the application. It does not perform any check itself. External check logic receives a request carrying a stage number and answers with a done strobe and a pass bit. A stage becomes enabled only after the stage below it has passed, so the enable vector always forms a contiguous run of ones from stage 0 up to the current level.

Checks are launched on a programmable interval tick. Most check slots go to the highest enabled stage, which is how bring-up moves forward. A fixed share of slots is spent revisiting the lower stages in rotation, so a change in the environment is caught after start-up as well. When any check fails, or the check logic does not answer in time, the level falls back to the failing stage, everything above it is disabled, and the application enable drops at once. Bring-up then climbs again from that stage.

Top module: `stage_bringup_seq`

## Requirements
- R1: During and right after a synchronous active-low reset, the level is 0, the enable vector is 1 (only stage 0), and the application enable, the check request and the rollback pulse are all low.
- R2: A tick occurs once every `interval_i` cycles, with 0 treated as 1. A check is launched on a tick only when no check is outstanding, and ticks that arrive while a check is outstanding are dropped. With a check logic that answers at once, successive requests therefore rise `max(interval_i, 2)` cycles apart.
- R3: At most one check is outstanding. The request stays high with a stable stage number until it is answered, the pass bit is sampled in the cycle done is high, and the request is low in the cycle after done.
- R4: A passing check of the top stage L, where L < 10, raises the level to L+1 in the cycle after done. The enable vector has bit i set exactly when i <= level.
- R5: Launched checks are counted from reset as slots 0, 1, 2 and so on. A slot whose number mod 4 equals 3, taken while the level is above 0, checks the revisit stage. Every other slot checks the top stage. The revisit stage starts at 0, steps by one after each revisit, and wraps to 0 once it reaches the level.
- R6: A failing check of stage k sets the level to k in the cycle after the answer. Stages above k are disabled, and the revisit stage returns to 0.
- R7: Each failed check, whether answered with pass low or timed out, produces a rollback pulse exactly one cycle long, in the same cycle the level changes. A passing check produces no pulse.
- R8: A request left unanswered for TIMEOUT cycles counts as a failure. The request is high for exactly TIMEOUT cycles in that case. An answer in the last of those cycles is still accepted.
- R9: The application enable is high exactly when the level is 10. A passing revisit of a lower stage leaves the level unchanged.
- R10: A passing check of stage 10 keeps the level at 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| interval_i | input | IV_W | Tick period in cycles (0 acts as 1) |
| chk_req_o | output | 1 | Check request, held until answered or timed out |
| chk_stage_o | output | SW | Stage number of the outstanding check |
| chk_done_i | input | 1 | Check logic answer strobe |
| chk_pass_i | input | 1 | Check verdict, sampled with done |
| stage_en_o | output | NUM_STAGES | Enabled stages, thermometer coded from bit 0 |
| level_o | output | SW | Highest enabled stage (4 bits by default) |
| app_en_o | output | 1 | Application enable (level at last stage) |
| rollback_o | output | 1 | One-cycle pulse on each failed check |

## Verification
The bench keeps the default eleven stages and revisits every fourth slot, but builds the block with TIMEOUT set to 6. At that value the exact duration of an unanswered request and the accept-in-the-last-cycle boundary can be checked quickly. The tick period is swept over 0, 1, 2, 3, 5 and 7, which exercises both the busy-limited spacing and the tick-limited spacing. The bench then forces a failure at every stage from 0 to 10 starting from full bring-up, alternating between explicit fails and timeouts, and predicts each launched stage number from its own slot and rotation arithmetic.

// File: rtl/stage_seq_pkg.sv
// Package: shared types for the staged bring-up sequencer.
// Assumes: included first in compile order.
package stage_seq_pkg;

    // State of the single-outstanding check handshake.
    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_WAIT = 1'b1
    } port_state_e;

endpackage

// File: rtl/seq_tick_gen.sv
// Module: seq_tick_gen
// Produces a registered one-cycle tick once every interval_i cycles.
// Assumes: interval_i may change at any time; a value of 0 behaves as 1.
module seq_tick_gen #(
    parameter int IV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IV_W-1:0] interval_i,
    output logic            tick_o
);

    logic [IV_W-1:0] cnt_q;
    logic            wrap;

    // Wrap when the next count would reach the programmed period.
    assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, interval_i};

    // Free-running period counter with a registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o && (interval_i > 1) && $stable(interval_i) |=> !tick_o); // R2

endmodule

// File: rtl/seq_scheduler.sv
// Module: seq_scheduler
// Chooses the stage for each launched check: the top stage, or on every
// REVISIT_EVERY-th slot a lower stage taken in round-robin order.
// Assumes: REVISIT_EVERY >= 2; clr_i and issue_i never coincide.
module seq_scheduler #(
    parameter int NUM_STAGES    = 11,
    parameter int REVISIT_EVERY = 4,
    localparam int SW  = $clog2(NUM_STAGES),
    localparam int SLW = (REVISIT_EVERY > 1) ? $clog2(REVISIT_EVERY) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic          clr_i,
    input  logic [SW-1:0] level_i,
    output logic [SW-1:0] target_o
);

    logic [SLW-1:0] slot_q;
    logic [SW-1:0]  rr_q;
    logic           last_slot;
    logic           revisit;

    assign last_slot = (slot_q == SLW'(REVISIT_EVERY - 1));
    // A revisit slot needs at least one stage below the top.
    assign revisit   = last_slot && (level_i != '0);
    assign target_o  = revisit ? rr_q : level_i;

    // Count launched checks modulo the revisit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (issue_i) begin
            slot_q <= last_slot ? '0 : slot_q + 1'b1;
        end
    end

    // Round-robin pointer over the stages below the top; cleared on failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (clr_i) begin
            rr_q <= '0;
        end else if (issue_i && revisit) begin
            rr_q <= ((rr_q + 1'b1) >= level_i) ? '0 : rr_q + 1'b1;
        end
    end

    AST_TARGET_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> target_o <= level_i); // R5
    AST_RR_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i != '0) |-> rr_q < level_i); // R5

endmodule

// File: rtl/seq_check_port.sv
// Module: seq_check_port
// Runs the request/done/pass handshake for one check at a time and turns a
// missing answer after TIMEOUT cycles into a failure result.
// Assumes: start_i is only raised while idle; result is valid for one cycle.
module seq_check_port
    import stage_seq_pkg::*;
#(
    parameter int SW      = 4,
    parameter int TIMEOUT = 64,
    localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [SW-1:0] start_stage_i,
    input  logic          done_i,
    input  logic          pass_i,
    output logic          req_o,
    output logic [SW-1:0] stage_o,
    output logic          busy_o,
    output logic          res_valid_o,
    output logic          res_pass_o,
    output logic [SW-1:0] res_stage_o
);

    port_state_e   state_q;
    logic [SW-1:0] stage_q;
    logic [TW-1:0] wait_q;
    logic          expire;

    assign expire      = (wait_q == TW'(TIMEOUT - 1));
    assign req_o       = (state_q == PORT_WAIT);
    assign busy_o      = req_o;
    assign stage_o     = stage_q;
    // An answer wins over an expiry in the same cycle.
    assign res_valid_o = req_o && (done_i || expire);
    assign res_pass_o  = done_i && pass_i;
    assign res_stage_o = stage_q;

    // Handshake state, latched stage number and wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
            stage_q <= '0;
            wait_q  <= '0;
        end else begin
            case (state_q)
                PORT_IDLE: begin
                    if (start_i) begin
                        state_q <= PORT_WAIT;
                        stage_q <= start_stage_i;
                        wait_q  <= '0;
                    end
                end
                PORT_WAIT: begin
                    if (res_valid_o) begin
                        state_q <= PORT_IDLE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                default: state_q <= PORT_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !res_valid_o |=> req_o && $stable(stage_o)); // R3
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !req_o); // R3
    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !req_o); // R3
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> wait_q <= TW'(TIMEOUT - 1)); // R8

endmodule

// File: rtl/seq_level_ctrl.sv
// Module: seq_level_ctrl
// Holds the enable level, derives the thermometer enable vector and the
// application enable, and raises a one-cycle pulse on every failure.
// Assumes: result inputs are valid for one cycle per finished check.
module seq_level_ctrl #(
    parameter int NUM_STAGES = 11,
    localparam int SW   = $clog2(NUM_STAGES),
    localparam int LAST = NUM_STAGES - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  res_valid_i,
    input  logic                  res_pass_i,
    input  logic [SW-1:0]         res_stage_i,
    output logic [SW-1:0]         level_o,
    output logic [NUM_STAGES-1:0] stage_en_o,
    output logic                  app_en_o,
    output logic                  rollback_o
);

    logic [SW-1:0] level_q;
    logic          at_last;

    assign at_last  = (level_q == SW'(LAST));
    assign level_o  = level_q;
    assign app_en_o = stage_en_o[LAST];

    // Thermometer enable vector: one bit per stage at or below the level.
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_en
        assign stage_en_o[g] = (level_q >= SW'(g));
    end

    // Level update: climb on a top-stage pass, fall back on any failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q    <= '0;
            rollback_o <= 1'b0;
        end else begin
            rollback_o <= res_valid_i && !res_pass_i;
            if (res_valid_i && !res_pass_i) begin
                level_q <= res_stage_i;
            end else if (res_valid_i && (res_stage_i == level_q) && !at_last) begin
                level_q <= level_q + 1'b1;
            end
        end
    end

    AST_EN_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en_o[0] && (((stage_en_o + 1'b1) & stage_en_o) == '0)); // R4
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_i && res_pass_i |=>
        (level_q == $past(level_q)) || (level_q == $past(level_q) + 1'b1)); // R4
    AST_FAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_i && !res_pass_i |=> level_q == $past(res_stage_i)); // R6
    AST_ROLLBACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_o |=> !rollback_o); // R7
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_i |=> $stable(level_q) && !rollback_o); // R7
    AST_APP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        app_en_o |-> (&stage_en_o)); // R9

endmodule

// File: rtl/stage_bringup_seq.sv
// Module: stage_bringup_seq (top)
// Staged self-check bring-up sequencer: launches checks on interval ticks,
// advances the enable level on passes and rolls it back on failures.
// Assumes: external check logic answers with a done strobe and pass bit.
module stage_bringup_seq #(
    parameter int NUM_STAGES    = 11,
    parameter int IV_W          = 16,
    parameter int TIMEOUT       = 64,
    parameter int REVISIT_EVERY = 4,
    localparam int SW = $clog2(NUM_STAGES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IV_W-1:0]       interval_i,
    output logic                  chk_req_o,
    output logic [SW-1:0]         chk_stage_o,
    input  logic                  chk_done_i,
    input  logic                  chk_pass_i,
    output logic [NUM_STAGES-1:0] stage_en_o,
    output logic [SW-1:0]         level_o,
    output logic                  app_en_o,
    output logic                  rollback_o
);

    logic          tick;
    logic          busy;
    logic          issue;
    logic          clr_rr;
    logic [SW-1:0] target;
    logic          res_valid;
    logic          res_pass;
    logic [SW-1:0] res_stage;

    // Launch only on a tick while nothing is outstanding.
    assign issue  = tick && !busy;
    assign clr_rr = res_valid && !res_pass;

    seq_tick_gen #(
        .IV_W (IV_W)
    ) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .interval_i (interval_i),
        .tick_o     (tick)
    );

    seq_scheduler #(
        .NUM_STAGES    (NUM_STAGES),
        .REVISIT_EVERY (REVISIT_EVERY)
    ) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue),
        .clr_i    (clr_rr),
        .level_i  (level_o),
        .target_o (target)
    );

    seq_check_port #(
        .SW      (SW),
        .TIMEOUT (TIMEOUT)
    ) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (issue),
        .start_stage_i (target),
        .done_i        (chk_done_i),
        .pass_i        (chk_pass_i),
        .req_o         (chk_req_o),
        .stage_o       (chk_stage_o),
        .busy_o        (busy),
        .res_valid_o   (res_valid),
        .res_pass_o    (res_pass),
        .res_stage_o   (res_stage)
    );

    seq_level_ctrl #(
        .NUM_STAGES (NUM_STAGES)
    ) u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid_i (res_valid),
        .res_pass_i  (res_pass),
        .res_stage_i (res_stage),
        .level_o     (level_o),
        .stage_en_o  (stage_en_o),
        .app_en_o    (app_en_o),
        .rollback_o  (rollback_o)
    );

    AST_REQ_STAGE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req_o |-> stage_en_o[chk_stage_o]); // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !chk_req_o && !rollback_o && (level_o == '0)); // R1

endmodule

// File: tb/test_stage_bringup_seq.sv
// Bench: models the launch order, level and rollback arithmetically and acts
// as the external check logic.
module test_stage_bringup_seq;

    localparam int NST   = 11;
    localparam int LASTS = NST - 1;
    localparam int TMO   = 6;
    localparam int IVW   = 16;
    localparam int SWB   = $clog2(NST);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [IVW-1:0] interval = 16'd3;
    logic           done = 1'b0;
    logic           pass = 1'b0;
    logic           chk_req_o;
    logic [SWB-1:0] chk_stage_o;
    logic [NST-1:0] stage_en_o;
    logic [SWB-1:0] level_o;
    logic           app_en_o;
    logic           rollback_o;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    int m_level = 0;
    int m_slot = 0;
    int m_rr = 0;
    int last_rise = 0;

    stage_bringup_seq #(
        .NUM_STAGES (NST),
        .IV_W       (IVW),
        .TIMEOUT    (TMO)
    ) i_stage_bringup_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .interval_i  (interval),
        .chk_req_o   (chk_req_o),
        .chk_stage_o (chk_stage_o),
        .chk_done_i  (done),
        .chk_pass_i  (pass),
        .stage_en_o  (stage_en_o),
        .level_o     (level_o),
        .app_en_o    (app_en_o),
        .rollback_o  (rollback_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    function automatic int predict();
        return (m_slot == 3 && m_level > 0) ? m_rr : m_level;
    endfunction

    // Act as check logic for one launched check; silent means never answer.
    task automatic serve(input bit ok, input int lat, input bit silent, output int spacing);
        int exp_st;
        int old_level;
        int guard;
        int held;
        bit failed;
        guard = 0;
        spacing = -1;
        while (chk_req_o !== 1'b1) begin
            @(negedge clk);
            guard++;
            if (guard > 200) begin
                check(1'b0, "R2 request launched", 0, 1);
                return;
            end
        end
        spacing = cyc - last_rise;
        last_rise = cyc;
        exp_st = predict();
        old_level = m_level;
        check(int'(chk_stage_o) == exp_st,
              (exp_st < m_level) ? "R5 revisit stage" : "R5 top stage",
              int'(chk_stage_o), exp_st);
        if (m_slot == 3 && m_level > 0) m_rr = (m_rr + 1 >= m_level) ? 0 : m_rr + 1;
        m_slot = (m_slot + 1) % 4;
        failed = silent || !ok;
        if (silent) begin
            held = 0;
            while (chk_req_o === 1'b1 && held < 100) begin
                held++;
                @(negedge clk);
            end
            check(held == TMO, "R8 request held until timeout", held, TMO);
        end else begin
            for (int c = 0; c < lat; c++) begin
                @(negedge clk);
                check(chk_req_o === 1'b1 && int'(chk_stage_o) == exp_st,
                      "R3 request held with stable stage", int'(chk_stage_o), exp_st);
            end
            done = 1'b1;
            pass = ok;
            @(negedge clk);
            done = 1'b0;
            pass = 1'b0;
            check(chk_req_o == 1'b0, "R3 request released after done", chk_req_o, 0);
        end
        if (failed) begin
            m_level = exp_st;
            m_rr = 0;
        end else if (exp_st == m_level && m_level < LASTS) begin
            m_level++;
        end
        if (failed)
            check(int'(level_o) == m_level, "R6 level after failure", int'(level_o), m_level);
        else if (exp_st == LASTS)
            check(int'(level_o) == m_level, "R10 level stays at last stage", int'(level_o), m_level);
        else if (exp_st < old_level)
            check(int'(level_o) == m_level, "R9 revisit pass keeps level", int'(level_o), m_level);
        else
            check(int'(level_o) == m_level, "R4 level advance", int'(level_o), m_level);
        check(int'(stage_en_o) == (1 << (m_level + 1)) - 1, "R4 enable vector",
              int'(stage_en_o), (1 << (m_level + 1)) - 1);
        check(app_en_o == (m_level == LASTS), "R9 application enable",
              app_en_o, int'(m_level == LASTS));
        check(rollback_o == failed, "R7 rollback pulse", rollback_o, int'(failed));
        if (failed) begin
            @(negedge clk);
            check(rollback_o == 1'b0, "R7 rollback one cycle", rollback_o, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R3: actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        int sp;
        int expsp;
        int guard;
        int ivs[6] = '{2, 3, 5, 0, 1, 7};
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(level_o == '0, "R1 level in reset", int'(level_o), 0);
        check(int'(stage_en_o) == 1, "R1 enable vector in reset", int'(stage_en_o), 1);
        check(app_en_o == 1'b0, "R1 app enable in reset", app_en_o, 0);
        check(chk_req_o == 1'b0, "R1 request in reset", chk_req_o, 0);
        check(rollback_o == 1'b0, "R1 rollback in reset", rollback_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(level_o == '0 && chk_req_o == 1'b0, "R1 level right after reset", int'(level_o), 0);

        // R2: tick spacing sweep with an immediate answer
        for (int i = 0; i < 6; i++) begin
            interval = IVW'(ivs[i]);
            expsp = (ivs[i] <= 2) ? 2 : ivs[i];
            for (int j = 0; j < 6; j++) begin
                serve(1'b1, 0, 1'b0, sp);
                if (j >= 2) check(sp == expsp, "R2 request spacing", sp, expsp);
            end
        end

        // R3/R8: slow answers, including one in the last allowed cycle
        interval = 16'd3;
        serve(1'b1, TMO - 1, 1'b0, sp);
        serve(1'b1, 2, 1'b0, sp);
        serve(1'b1, 1, 1'b0, sp);

        // R6/R7/R8/R9: fail each stage starting from full bring-up
        for (int k = 0; k <= LASTS; k++) begin
            guard = 0;
            while (m_level < LASTS && guard < 100) begin
                serve(1'b1, 0, 1'b0, sp);
                guard++;
            end
            guard = 0;
            while (predict() != k && guard < 100) begin
                serve(1'b1, 0, 1'b0, sp);
                guard++;
            end
            check(predict() == k, "R5 revisit reaches stage", predict(), k);
            serve(1'b0, 1, (k % 2) == 1, sp);
        end

        finish_run();
    end

endmodule